// File: doc/BRIEF.md
# Page-Map Address Translation Unit

This block turns a virtual address from a processor into a physical address. It uses a small page map that sits in flip-flops on chip. The low bits of the virtual address are the page offset and pass through untouched. The high bits are the virtual page number, and they select one entry of the map directly. Each entry carries four things:

- a resident flag;
- a dirty flag;
- an optional write-protect flag;
- a physical page number.

Two kinds of access fault:

- An access to a page that is not resident reports a page fault.
- A store to a write-protected resident page reports a protection fault.

A store that completes sets the dirty flag of its page. The page can then be written back before it is reused.

A fault handler manages the map through a separate maintenance port. It can write a whole entry to install or evict a mapping. It can also read any entry back at any time, for example to see whether a page it is about to evict is dirty. Each access returns its result one clock cycle later.

Top module: `pmu_xlate`

## Requirements
- R1: The virtual address is split as follows: bits [7:0] are the page offset and bits [11:8] are the virtual page number. The virtual page number selects map entry number equal to its own value, out of 16 entries.
- R2: On a hit, the physical address is the entry's 3-bit physical page number in bits [10:8] and the unchanged offset in bits [7:0]. For example, with entry 2 resident and mapped to physical page 4, virtual address 0x2C8 gives 0x4C8.
- R3: The result of an access appears on the cycle after `acc_valid` is sampled. In a cycle that follows a cycle with no access, `res_hit`, `res_page_fault`, `res_prot_fault` and `res_paddr` are all 0.
- R4: After reset every entry reads back as 0: not resident, clean, writable, physical page 0. Any access then reports a page fault.
- R5: An access to an entry whose resident flag is 0 reports `res_page_fault`. It does not report a hit, `res_paddr` is 0, and the entry's dirty flag is left unchanged.
- R6: A store (`acc_store`=1) that hits a resident writable page sets that entry's dirty flag. A load leaves the dirty flag unchanged.
- R7: A store to a resident entry whose write-protect flag is 1 reports `res_prot_fault` and no hit, and it leaves the dirty flag unchanged. A load of the same page hits.
- R8: At most one of `res_hit`, `res_page_fault` and `res_prot_fault` is 1 in any cycle. A store to an entry that is both non-resident and write-protected reports only the page fault.
- R9: A maintenance write (`upd_wr`=1) replaces all four fields of entry `upd_idx` at the clock edge. The read-back port shows entry `rd_idx` combinationally.
- R10: If a maintenance write and a store-driven dirty set hit the same entry in one cycle, the written value wins. If they hit different entries, both take effect.
- R11: An access that falls in the same cycle as a maintenance write to its entry is judged against the entry's value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_vaddr | input | 12 | Virtual address |
| acc_store | input | 1 | 1 = store, 0 = load |
| res_hit | output | 1 | Previous access translated |
| res_page_fault | output | 1 | Previous access found its page not resident |
| res_prot_fault | output | 1 | Previous access was a store to a write-protected page |
| res_paddr | output | 11 | Physical address of a hit, else 0 |
| upd_wr | input | 1 | Maintenance write strobe |
| upd_idx | input | 4 | Entry to write |
| upd_resident | input | 1 | Resident flag to write |
| upd_dirty | input | 1 | Dirty flag to write |
| upd_ro | input | 1 | Write-protect flag to write |
| upd_ppn | input | 3 | Physical page number to write |
| rd_idx | input | 4 | Entry to read back |
| rd_resident | output | 1 | Read-back resident flag |
| rd_dirty | output | 1 | Read-back dirty flag |
| rd_ro | output | 1 | Read-back write-protect flag |
| rd_ppn | output | 3 | Read-back physical page number |

## Verification
Two functions can meet in one cycle. A store may be setting an entry's dirty flag while the maintenance port writes an entry.

The bench provokes this both ways:

- A store to entry 3 is paired with a write of entry 3 that carries dirty=0. The read-back must then show the written value.
- A store to entry 3 is paired with a write to a different entry. Both changes must then be visible.

In both cases the store itself must be judged against the entry as it stood before the write. A reference model in the bench applies the dirty set first and the write second, and predicts both the access result and the read-back.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

   typedef struct packed {
      logic resident;
      logic dirty;
      logic ro;
   } pmu_flags_t;

   typedef enum logic [1:0] {
      RES_NONE   = 2'd0,
      RES_HIT    = 2'd1,
      RES_PFAULT = 2'd2,
      RES_PROT   = 2'd3
   } pmu_result_e;

endpackage

// File: rtl/pmu_map_regs.sv
module pmu_map_regs
   import pmu_pkg::*;
#(
   parameter int VPN_W  = 4,
   parameter int PPN_W  = 3,
   parameter bit HAS_RO = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [VPN_W-1:0] wr_idx,
   input  pmu_flags_t       wr_flags,
   input  logic [PPN_W-1:0] wr_ppn,
   input  logic             set_en,
   input  logic [VPN_W-1:0] set_idx,
   input  logic [VPN_W-1:0] lk_idx,
   output pmu_flags_t       lk_flags,
   output logic [PPN_W-1:0] lk_ppn,
   input  logic [VPN_W-1:0] rd_idx,
   output pmu_flags_t       rd_flags,
   output logic [PPN_W-1:0] rd_ppn
);

   localparam int NUM = 1 << VPN_W;

   pmu_flags_t       flags_q [NUM];
   logic [PPN_W-1:0] ppn_q   [NUM];
   logic             wr_ro_eff;

   generate
      if (HAS_RO) begin : g_ro
         assign wr_ro_eff = wr_flags.ro;
      end else begin : g_no_ro
         assign wr_ro_eff = 1'b0;
      end
   endgenerate

   generate
      for (genvar i = 0; i < NUM; i++) begin : g_ent
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               flags_q[i] <= '0;
               ppn_q[i]   <= '0;
            end else if (wr_en && wr_idx == VPN_W'(i)) begin
               flags_q[i].resident <= wr_flags.resident;
               flags_q[i].dirty    <= wr_flags.dirty;
               flags_q[i].ro       <= wr_ro_eff;
               ppn_q[i]            <= wr_ppn;
            end else if (set_en && set_idx == VPN_W'(i)) begin
               flags_q[i].dirty <= 1'b1;
            end
         end
      end
   endgenerate

   assign lk_flags = flags_q[lk_idx];
   assign lk_ppn   = ppn_q[lk_idx];
   assign rd_flags = flags_q[rd_idx];
   assign rd_ppn   = ppn_q[rd_idx];

   logic armed_q;
   always_ff @(posedge clk) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;
   end

   // R6: a dirty set that no write overrides leaves the entry dirty
   assert_dirty_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && $past(set_en && !(wr_en && wr_idx == set_idx)))
         |-> flags_q[$past(set_idx)].dirty);

   // R10: the maintenance write lands in full, even against a dirty set
   assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && $past(wr_en))
         |-> (flags_q[$past(wr_idx)].dirty == $past(wr_flags.dirty)
              && flags_q[$past(wr_idx)].resident == $past(wr_flags.resident)
              && ppn_q[$past(wr_idx)] == $past(wr_ppn)));

endmodule

// File: rtl/pmu_classify.sv
module pmu_classify
   import pmu_pkg::*;
(
   input  logic        acc_valid,
   input  logic        acc_store,
   input  pmu_flags_t  flags,
   output pmu_result_e kind,
   output logic        set_dirty
);

   always_comb begin
      kind = RES_NONE;
      if (acc_valid) begin
         if (!flags.resident)             kind = RES_PFAULT;
         else if (acc_store && flags.ro)  kind = RES_PROT;
         else                             kind = RES_HIT;
      end
      set_dirty = (kind == RES_HIT) && acc_store;
   end

endmodule

// File: rtl/pmu_xlate.sv
module pmu_xlate
   import pmu_pkg::*;
#(
   parameter int VA_W   = 12,
   parameter int PA_W   = 11,
   parameter int OFS_W  = 8,
   parameter bit HAS_RO = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc_valid,
   input  logic [VA_W-1:0]       acc_vaddr,
   input  logic                  acc_store,
   output logic                  res_hit,
   output logic                  res_page_fault,
   output logic                  res_prot_fault,
   output logic [PA_W-1:0]       res_paddr,
   input  logic                  upd_wr,
   input  logic [VA_W-OFS_W-1:0] upd_idx,
   input  logic                  upd_resident,
   input  logic                  upd_dirty,
   input  logic                  upd_ro,
   input  logic [PA_W-OFS_W-1:0] upd_ppn,
   input  logic [VA_W-OFS_W-1:0] rd_idx,
   output logic                  rd_resident,
   output logic                  rd_dirty,
   output logic                  rd_ro,
   output logic [PA_W-OFS_W-1:0] rd_ppn
);

   localparam int VPN_W = VA_W - OFS_W;
   localparam int PPN_W = PA_W - OFS_W;

   generate
      if (VPN_W < 1) begin : g_bad_va
         $error("pmu_xlate: VA_W must exceed OFS_W");
      end
      if (PPN_W < 1) begin : g_bad_pa
         $error("pmu_xlate: PA_W must exceed OFS_W");
      end
      if (VPN_W > 10) begin : g_bad_map
         $error("pmu_xlate: page map too large for flip-flops");
      end
   endgenerate

   logic [VPN_W-1:0] vpn;
   logic [OFS_W-1:0] ofs;
   assign vpn = acc_vaddr[VA_W-1:OFS_W];
   assign ofs = acc_vaddr[OFS_W-1:0];

   pmu_flags_t       lk_flags, rd_flags, wr_flags;
   logic [PPN_W-1:0] lk_ppn;
   pmu_result_e      kind;
   logic             set_dirty;

   assign wr_flags = '{resident: upd_resident, dirty: upd_dirty, ro: upd_ro};

   pmu_map_regs #(.VPN_W(VPN_W), .PPN_W(PPN_W), .HAS_RO(HAS_RO)) u_map (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (upd_wr),
      .wr_idx   (upd_idx),
      .wr_flags (wr_flags),
      .wr_ppn   (upd_ppn),
      .set_en   (set_dirty),
      .set_idx  (vpn),
      .lk_idx   (vpn),
      .lk_flags (lk_flags),
      .lk_ppn   (lk_ppn),
      .rd_idx   (rd_idx),
      .rd_flags (rd_flags),
      .rd_ppn   (rd_ppn)
   );

   pmu_classify u_cls (
      .acc_valid (acc_valid),
      .acc_store (acc_store),
      .flags     (lk_flags),
      .kind      (kind),
      .set_dirty (set_dirty)
   );

   pmu_result_e     kind_q;
   logic [PA_W-1:0] paddr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q  <= RES_NONE;
         paddr_q <= '0;
      end else begin
         kind_q  <= kind;
         paddr_q <= (kind == RES_HIT) ? {lk_ppn, ofs} : '0;
      end
   end

   assign res_hit        = (kind_q == RES_HIT);
   assign res_page_fault = (kind_q == RES_PFAULT);
   assign res_prot_fault = (kind_q == RES_PROT);
   assign res_paddr      = paddr_q;
   assign rd_resident    = rd_flags.resident;
   assign rd_dirty       = rd_flags.dirty;
   assign rd_ro          = rd_flags.ro;

   logic armed_q;
   always_ff @(posedge clk) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;
   end

   assert_one_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({res_hit, res_page_fault, res_prot_fault}));

   assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && !$past(acc_valid))
         |-> !(res_hit || res_page_fault || res_prot_fault || res_paddr != '0));

   assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && res_hit) |-> res_paddr[OFS_W-1:0] == $past(acc_vaddr[OFS_W-1:0]));

   assert_fault_no_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      res_page_fault |-> res_paddr == '0);

endmodule

// File: tb/tb_pmu_xlate.sv
module tb_pmu_xlate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [11:0] acc_vaddr = '0;
   logic        acc_store = 1'b0;
   logic        res_hit, res_page_fault, res_prot_fault;
   logic [10:0] res_paddr;
   logic        upd_wr = 1'b0;
   logic [3:0]  upd_idx = '0;
   logic        upd_resident = 1'b0, upd_dirty = 1'b0, upd_ro = 1'b0;
   logic [2:0]  upd_ppn = '0;
   logic [3:0]  rd_idx = '0;
   logic        rd_resident, rd_dirty, rd_ro;
   logic [2:0]  rd_ppn;

   always #4 clk = ~clk;

   pmu_xlate dut (.*);

   int checks = 0;
   int errors = 0;

   // Reference model of the map
   bit       m_res [16];
   bit       m_dirty [16];
   bit       m_ro [16];
   bit [2:0] m_ppn [16];

   // Expected results: {hit, pfault, pfault_prot, paddr}
   typedef struct packed {
      logic        hit;
      logic        pf;
      logic        prot;
      logic [10:0] paddr;
   } exp_t;
   exp_t exp_q [$];
   string tag_q [$];

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // One cycle of stimulus: optional access and optional maintenance write
   task automatic cyc(string req, bit acc, logic [11:0] va, bit st,
                      bit wr, logic [3:0] idx, bit r, bit d, bit ro, logic [2:0] ppn);
      exp_t e;
      int   v;
      @(negedge clk);
      acc_valid = acc; acc_vaddr = va; acc_store = st;
      upd_wr = wr; upd_idx = idx; upd_resident = r; upd_dirty = d;
      upd_ro = ro; upd_ppn = ppn;
      if (acc) begin
         v = int'(va[11:8]);
         e = '0;
         if (!m_res[v])              e.pf = 1'b1;
         else if (st && m_ro[v])     e.prot = 1'b1;
         else begin
            e.hit = 1'b1;
            e.paddr = {m_ppn[v], va[7:0]};
            if (st) m_dirty[v] = 1'b1;
         end
         exp_q.push_back(e);
         tag_q.push_back(req);
      end
      if (wr) begin
         m_res[idx] = r; m_dirty[idx] = d; m_ro[idx] = ro; m_ppn[idx] = ppn;
      end
   endtask

   task automatic idle();
      @(negedge clk);
      acc_valid = 1'b0; upd_wr = 1'b0;
   endtask

   task automatic check_rd(string req, logic [3:0] idx);
      idle();
      rd_idx = idx;
      #1;
      check(req, {rd_resident, rd_dirty, rd_ro, rd_ppn},
                 {m_res[idx], m_dirty[idx], m_ro[idx], m_ppn[idx]});
   endtask

   // Monitor: pops one expectation per sampled access
   always @(posedge clk) begin
      bit   was_acc;
      exp_t e;
      string t;
      was_acc = rst_n && acc_valid;
      #2;
      if (rst_n) begin
         if (was_acc) begin
            if (exp_q.size() == 0) begin
               checks++; errors++;
               $display("FAIL R3: result with no expectation, actual %0h expected none",
                        {res_hit, res_page_fault, res_prot_fault, res_paddr});
            end else begin
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(t, {res_hit, res_page_fault, res_prot_fault, res_paddr}, e);
            end
         end else begin
            check("R3 idle", {res_hit, res_page_fault, res_prot_fault, res_paddr}, '0);
         end
      end
   end

   initial begin
      #(200000 * 8);
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         m_res[i] = 0; m_dirty[i] = 0; m_ro[i] = 0; m_ppn[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R4: reset state
      check_rd("R4 entry0", 4'd0);
      check_rd("R4 entry5", 4'd5);
      check_rd("R4 entry15", 4'd15);
      cyc("R4 first access faults", 1, 12'h123, 0, 0, 0, 0, 0, 0, 0);
      cyc("R5 store to empty page", 1, 12'h7FF, 1, 0, 0, 0, 0, 0, 0);
      check_rd("R5 dirty untouched", 4'd7);
      // R2 / R9: install entry 2 -> page 4
      cyc("R9 install", 0, 0, 0, 1, 4'd2, 1, 0, 0, 3'd4);
      check_rd("R9 readback", 4'd2);
      cyc("R2 worked example 0x2C8", 1, 12'h2C8, 0, 0, 0, 0, 0, 0, 0);
      check_rd("R6 load keeps clean", 4'd2);
      cyc("R6 store hit", 1, 12'h2FF, 1, 0, 0, 0, 0, 0, 0);
      check_rd("R6 dirty set", 4'd2);
      // R7: write-protected page
      cyc("R7 install ro", 0, 0, 0, 1, 4'd7, 1, 0, 1, 3'd1);
      cyc("R7 load of ro page", 1, 12'h700, 0, 0, 0, 0, 0, 0, 0);
      cyc("R7 store to ro page", 1, 12'h7AB, 1, 0, 0, 0, 0, 0, 0);
      check_rd("R7 dirty untouched", 4'd7);
      // R8: non-resident and ro -> page fault only
      cyc("R8 install nonres ro", 0, 0, 0, 1, 4'd9, 0, 0, 1, 3'd2);
      cyc("R8 fault priority", 1, 12'h955, 1, 0, 0, 0, 0, 0, 0);
      // R10: same-entry collision, write wins
      cyc("R10 install 3", 0, 0, 0, 1, 4'd3, 1, 0, 0, 3'd6);
      cyc("R10 store during rewrite", 1, 12'h310, 1, 1, 4'd3, 1, 0, 0, 3'd6);
      check_rd("R10 write wins", 4'd3);
      // R10: different entries both land
      cyc("R10 store other entry", 1, 12'h311, 1, 1, 4'd12, 1, 0, 0, 3'd5);
      check_rd("R10 dirty kept", 4'd3);
      check_rd("R10 other written", 4'd12);
      // R11: access judged against old entry
      cyc("R11 old value used", 1, 12'h5A0, 0, 1, 4'd5, 1, 0, 0, 3'd3);
      cyc("R11 new value next", 1, 12'h5A0, 0, 0, 0, 0, 0, 0, 0);
      // R1: every page, back to back
      for (int i = 0; i < 16; i++)
         cyc("R1 install", 0, 0, 0, 1, 4'(i), 1, 0, 0, 3'(i % 8));
      for (int i = 0; i < 16; i++)
         cyc("R1 sweep", 1, {4'(i), 8'(i * 17)}, i[0], 0, 0, 0, 0, 0, 0);
      check_rd("R1 odd stored dirty", 4'd11);
      check_rd("R1 even load clean", 4'd10);
      // Eviction
      cyc("R9 evict 2", 0, 0, 0, 1, 4'd2, 0, 0, 0, 3'd4);
      cyc("R5 evicted faults", 1, 12'h2C8, 0, 0, 0, 0, 0, 0, 0);
      idle();
      idle();
      check("R3 queue drained", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule